// File: doc/BRIEF.md
# Scanline Width and Spacing Rule Checker

This block sits after the true-point classifier in a scanline layout checker for Manhattan geometry. It takes one point per cycle, already sorted in scan order within a column. A column-marker word opens each column and carries that column's X position in its coordinate field. For every layer, the block remembers the coordinate, the orientation and the start/end kind of the most recent true point in the current column.

When a true point or a virtual point arrives, the block subtracts each remembered coordinate from the new one. It enables only the rules that the orientation pair makes meaningful and compares each difference with a limit from a parameter table. Violations are reported in a way that keeps each one from being reported twice. Alongside the checks, the block produces the points that the next column needs. A starting endpoint becomes a carried-over (old) point. Certain true ending endpoints create virtual points, which extend a boundary by the largest limit that concerns their layer.

Orientation 0 is a forward boundary (the region lies below the point's edge) and 1 is a backward boundary. Point kinds are coded 0 start, 1 end, 2 old, 3 virtual. Rule index `l` is the width rule of layer `l`. Rule index `NL + a*NL + b` is the spacing rule between a current point on layer `a` and a latest point on layer `b`. Default limits in half-grid units: width {6, 24, 4}; spacing 0-0 6, 0-1/1-0 12, 0-2/2-0 8, 1-1 36, 1-2/2-1 5, 2-2 4.

Top module: `rc_edge_rule_check`

## Requirements
- R1: While reset is low and on the first cycle after it, `err_valid` and `fwd_valid` are 0.
- R2: A same-layer width violation is reported when the layer's latest point is forward and the current point is backward, under two conditions: the coordinate rises by more than 0 and less than that layer's width limit, and the report condition of R5 holds. `err_rule` in that layer's slot is set to the layer number.
- R3: A spacing violation is reported under a different orientation pair: the latest point of layer `b` is backward and the current point on layer `a` is forward, with `a` equal to `b` or not. The coordinate must rise by more than 0 and less than spacing limit `(a,b)`, and R5 must hold. The rule index is `NL + a*NL + b`.
- R4: No rule is reported for a forward-forward or backward-backward pair, for a zero difference, or for a difference at or above the limit. Between different layers, no rule is reported when the latest point of the other layer is forward.
- R5: A violation is reported only in two cases: the current point is a true starting endpoint, or the latest point of the compared layer was a starting endpoint and the current point is true or virtual.
- R6: Several layers can violate against one current point. Each hit sets its own bit in `err_hit` at the index of the latest point's layer, with its own rule index.
- R7: Only true, non-virtual points replace a layer's latest point. Virtual points and points marked not true leave it unchanged.
- R8: A column marker forgets every layer's latest point, so no rule spans two columns. It also sets the X value that is reported with later errors.
- R9: Every starting endpoint, true or not, is sent out on the next-column port as an old point (`fwd_virtual`=0) with the same Y, layer and orientation.
- R10: A true ending endpoint creates a virtual point in two cases: it is forward with its right side outside the region, or it is backward with its right side inside. The virtual point keeps Y, layer and orientation, has `fwd_virtual`=1, and its extension is the largest width or spacing limit involving its layer (12, 36, 8 by default).
- R11: Error and next-column outputs appear exactly one clock after the input point is taken. `err_x`, `err_y` and `err_layer` give the column, the current point's Y and its layer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_marker | input | 1 | Word is a column marker; `in_y` carries X |
| in_y | input | CW | Point Y, or column X for a marker |
| in_layer | input | LYW | Layer of the point |
| in_orient | input | 1 | 0 forward, 1 backward |
| in_kind | input | 2 | 0 start, 1 end, 2 old, 3 virtual |
| in_true | input | 1 | Point lies on the merged region boundary |
| in_right_in | input | 1 | Right side of the point is inside the region |
| err_valid | output | 1 | At least one violation this cycle |
| err_hit | output | NL | Violating latest-point layers |
| err_rule | output | NL*RW | Rule index per slot, slot j at bits j*RW |
| err_layer | output | LYW | Layer of the current point |
| err_x | output | CW | Column X |
| err_y | output | CW | Current point Y |
| fwd_valid | output | 1 | Point for the next column |
| fwd_y | output | CW | Its Y |
| fwd_layer | output | LYW | Its layer |
| fwd_orient | output | 1 | Its orientation |
| fwd_virtual | output | 1 | 1 virtual point, 0 old point |
| fwd_xext | output | LW | Extension of a virtual point |

## Verification
Suppose a latest-point register holds the wrong value. This would stay hidden until the next true or virtual point on any layer in the same column. That point would then show a missing or extra `err_hit` bit, or a wrong rule index, one cycle later. A marker that failed to clear would show as a spurious error on the first opposite-orientation point of the new column. An update by a virtual or not-true point would show as a lost width hit on the following true point. The sweep covers every layer pair, orientation pair and kind pair against differences on both sides of each limit, so each such fault shows within a few points.

// File: rtl/rc_pkg.sv
// Shared types for the scanline rule checker.
package rc_pkg;
    typedef enum logic [1:0] {
        PK_START = 2'd0,
        PK_END   = 2'd1,
        PK_OLD   = 2'd2,
        PK_VIRT  = 2'd3
    } pkind_t;
endpackage

// File: rtl/rc_latest_bank.sv
// Per-layer memory of the latest true point in the current column.
// Assumes upd and clear are never high together (clear comes from markers).
module rc_latest_bank #(
    parameter int NL  = 3,
    parameter int CW  = 16,
    localparam int LYW = (NL > 1) ? $clog2(NL) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   upd,
    input  logic [LYW-1:0]         upd_layer,
    input  logic [CW-1:0]          upd_y,
    input  logic                   upd_orient,
    input  logic                   upd_start,
    output logic [NL-1:0]          lat_v,
    output logic [NL-1:0][CW-1:0]  lat_y,
    output logic [NL-1:0]          lat_o,
    output logic [NL-1:0]          lat_s
);
    for (genvar j = 0; j < NL; j++) begin : g_slot
        // Hold, clear or overwrite one layer's entry.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                lat_v[j] <= 1'b0;
                lat_y[j] <= '0;
                lat_o[j] <= 1'b0;
                lat_s[j] <= 1'b0;
            end else if (upd && (upd_layer == LYW'(j))) begin
                lat_v[j] <= 1'b1;
                lat_y[j] <= upd_y;
                lat_o[j] <= upd_orient;
                lat_s[j] <= upd_start;
            end
        end
    end

    // A marker leaves no layer with a remembered point.
    p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear) |-> (lat_v == '0));
endmodule

// File: rtl/rc_rule_eval.sv
// Compares the current point with each layer's latest point and flags
// the rules its orientation pair enables. Purely combinational.
// Assumes points arrive in rising Y order within a column.
module rc_rule_eval #(
    parameter int NL  = 3,
    parameter int CW  = 16,
    parameter int LW  = 8,
    parameter logic [NL-1:0][LW-1:0]    W_LIM = {8'd4, 8'd24, 8'd6},
    parameter logic [NL*NL-1:0][LW-1:0] S_LIM = {8'd4, 8'd5, 8'd8, 8'd5, 8'd36,
                                                 8'd12, 8'd8, 8'd12, 8'd6},
    localparam int LYW = (NL > 1) ? $clog2(NL) : 1,
    localparam int RW  = $clog2(NL + NL * NL)
) (
    input  logic                   part,
    input  logic                   cur_tstart,
    input  logic [LYW-1:0]         cur_layer,
    input  logic [CW-1:0]          cur_y,
    input  logic                   cur_o,
    input  logic [NL-1:0]          lat_v,
    input  logic [NL-1:0][CW-1:0]  lat_y,
    input  logic [NL-1:0]          lat_o,
    input  logic [NL-1:0]          lat_s,
    output logic [NL-1:0]          hit,
    output logic [NL-1:0][RW-1:0]  rule
);
    for (genvar j = 0; j < NL; j++) begin : g_cmp
        logic          rel;
        logic [LW-1:0] lim;
        logic [CW-1:0] dy;
        logic          flag;

        // Pick the rule and limit this orientation pair enables.
        always_comb begin
            int sidx;
            sidx = int'(cur_layer) * NL + j;
            rel  = 1'b0;
            lim  = '0;
            rule[j] = '0;
            if ((cur_layer == LYW'(j)) && !lat_o[j] && cur_o) begin
                rel = 1'b1;
                lim = W_LIM[j];
                rule[j] = RW'(j);
            end else if (lat_o[j] && !cur_o && (sidx < NL * NL)) begin
                rel = 1'b1;
                lim = S_LIM[sidx];
                rule[j] = RW'(NL + sidx);
            end
        end

        // Distance check and the report-once condition.
        always_comb begin
            dy   = cur_y - lat_y[j];
            flag = cur_tstart || (lat_s[j] && part);
            hit[j] = part && lat_v[j] && rel && flag &&
                     (cur_y > lat_y[j]) && (dy < CW'(lim));
        end
    end
endmodule

// File: rtl/rc_next_gen.sv
// Builds the point handed to the next column: an old point for every
// starting endpoint, a virtual point for qualifying true ending endpoints.
module rc_next_gen #(
    parameter int NL  = 3,
    parameter int LW  = 8,
    parameter logic [NL-1:0][LW-1:0]    W_LIM = {8'd4, 8'd24, 8'd6},
    parameter logic [NL*NL-1:0][LW-1:0] S_LIM = {8'd4, 8'd5, 8'd8, 8'd5, 8'd36,
                                                 8'd12, 8'd8, 8'd12, 8'd6},
    localparam int LYW = (NL > 1) ? $clog2(NL) : 1
) (
    input  logic            pt_v,
    input  rc_pkg::pkind_t  kind,
    input  logic            is_true,
    input  logic            orient,
    input  logic            right_in,
    input  logic [LYW-1:0]  layer,
    output logic            nx_v,
    output logic            nx_virt,
    output logic [LW-1:0]   nx_xext
);
    // Largest limit that mentions layer l, in either role.
    function automatic logic [LW-1:0] ext_of(input int l);
        logic [LW-1:0] m;
        m = W_LIM[l];
        for (int k = 0; k < NL; k++) begin
            if (S_LIM[l * NL + k] > m) m = S_LIM[l * NL + k];
            if (S_LIM[k * NL + l] > m) m = S_LIM[k * NL + l];
        end
        return m;
    endfunction

    // Decide forwarding and the virtual-point extension.
    always_comb begin
        nx_virt = pt_v && (kind == rc_pkg::PK_END) && is_true &&
                  (orient ? right_in : !right_in);
        nx_v    = (pt_v && (kind == rc_pkg::PK_START)) || nx_virt;
        nx_xext = '0;
        if (nx_virt && (int'(layer) < NL)) nx_xext = ext_of(int'(layer));
    end
endmodule

// File: rtl/rc_edge_rule_check.sv
// Scanline width/spacing rule checker. Takes classified points in scan
// order, checks them against per-layer latest points, registers error
// records and next-column points with one cycle of latency.
// Assumes in_layer < NL and rising Y within each column.
module rc_edge_rule_check #(
    parameter int NL  = 3,
    parameter int CW  = 16,
    parameter int LW  = 8,
    parameter logic [NL-1:0][LW-1:0]    W_LIM = {8'd4, 8'd24, 8'd6},
    parameter logic [NL*NL-1:0][LW-1:0] S_LIM = {8'd4, 8'd5, 8'd8, 8'd5, 8'd36,
                                                 8'd12, 8'd8, 8'd12, 8'd6},
    localparam int LYW = (NL > 1) ? $clog2(NL) : 1,
    localparam int RW  = $clog2(NL + NL * NL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_marker,
    input  logic [CW-1:0]     in_y,
    input  logic [LYW-1:0]    in_layer,
    input  logic              in_orient,
    input  logic [1:0]        in_kind,
    input  logic              in_true,
    input  logic              in_right_in,
    output logic              err_valid,
    output logic [NL-1:0]     err_hit,
    output logic [NL*RW-1:0]  err_rule,
    output logic [LYW-1:0]    err_layer,
    output logic [CW-1:0]     err_x,
    output logic [CW-1:0]     err_y,
    output logic              fwd_valid,
    output logic [CW-1:0]     fwd_y,
    output logic [LYW-1:0]    fwd_layer,
    output logic              fwd_orient,
    output logic              fwd_virtual,
    output logic [LW-1:0]     fwd_xext
);
    import rc_pkg::*;

    pkind_t                kind;
    logic                  pt_v, part, upd, cur_tstart, clear;
    logic [NL-1:0]         lat_v, lat_o, lat_s, hit;
    logic [NL-1:0][CW-1:0] lat_y;
    logic [NL-1:0][RW-1:0] rule;
    logic                  nx_v, nx_virt;
    logic [LW-1:0]         nx_xext;
    logic [CW-1:0]         cur_x;

    // Decode the role of the incoming word.
    always_comb begin
        kind       = pkind_t'(in_kind);
        clear      = in_valid && in_marker;
        pt_v       = in_valid && !in_marker;
        part       = pt_v && (in_true || (kind == PK_VIRT));
        upd        = pt_v && in_true && (kind != PK_VIRT);
        cur_tstart = pt_v && in_true && (kind == PK_START);
    end

    rc_latest_bank #(.NL(NL), .CW(CW)) i_bank (
        .clk(clk), .rst_n(rst_n), .clear(clear), .upd(upd),
        .upd_layer(in_layer), .upd_y(in_y), .upd_orient(in_orient),
        .upd_start(kind == PK_START),
        .lat_v(lat_v), .lat_y(lat_y), .lat_o(lat_o), .lat_s(lat_s)
    );

    rc_rule_eval #(.NL(NL), .CW(CW), .LW(LW), .W_LIM(W_LIM), .S_LIM(S_LIM)) i_eval (
        .part(part), .cur_tstart(cur_tstart), .cur_layer(in_layer),
        .cur_y(in_y), .cur_o(in_orient),
        .lat_v(lat_v), .lat_y(lat_y), .lat_o(lat_o), .lat_s(lat_s),
        .hit(hit), .rule(rule)
    );

    rc_next_gen #(.NL(NL), .LW(LW), .W_LIM(W_LIM), .S_LIM(S_LIM)) i_next (
        .pt_v(pt_v), .kind(kind), .is_true(in_true), .orient(in_orient),
        .right_in(in_right_in), .layer(in_layer),
        .nx_v(nx_v), .nx_virt(nx_virt), .nx_xext(nx_xext)
    );

    // Track the column X and register the output records.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_x       <= '0;
            err_valid   <= 1'b0;
            err_hit     <= '0;
            err_rule    <= '0;
            err_layer   <= '0;
            err_x       <= '0;
            err_y       <= '0;
            fwd_valid   <= 1'b0;
            fwd_y       <= '0;
            fwd_layer   <= '0;
            fwd_orient  <= 1'b0;
            fwd_virtual <= 1'b0;
            fwd_xext    <= '0;
        end else begin
            if (clear) cur_x <= in_y;
            err_valid   <= |hit;
            err_hit     <= hit;
            err_rule    <= rule;
            err_layer   <= in_layer;
            err_x       <= cur_x;
            err_y       <= in_y;
            fwd_valid   <= nx_v;
            fwd_y       <= in_y;
            fwd_layer   <= in_layer;
            fwd_orient  <= in_orient;
            fwd_virtual <= nx_virt;
            fwd_xext    <= nx_xext;
        end
    end

    // Errors only follow a true or virtual non-marker point.
    p_err_from_point_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> $past(in_valid && !in_marker && (in_true || in_kind == 2'd3)));
    // Virtual points leave the latest-point memory untouched.
    p_virt_keeps_latest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_marker && in_kind == 2'd3) |=> ($stable(lat_y) && $stable(lat_o)));
    // An old point leaving the block came from a starting endpoint.
    p_old_from_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && !fwd_virtual) |-> $past(in_valid && !in_marker && in_kind == 2'd0));
    // A virtual point always carries a nonzero extension.
    p_virt_has_ext_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && fwd_virtual) |-> (fwd_xext != '0));
endmodule

// File: tb/test_rc_edge_rule_check.sv
`timescale 1ns/1ps
module test_rc_edge_rule_check;
    localparam int NL = 3, CW = 16, LW = 8, LYW = 2, RW = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 0, in_marker = 0, in_orient = 0, in_true = 0, in_right_in = 0;
    logic [CW-1:0] in_y = '0;
    logic [LYW-1:0] in_layer = '0;
    logic [1:0] in_kind = '0;
    logic err_valid, fwd_valid, fwd_orient, fwd_virtual;
    logic [NL-1:0] err_hit;
    logic [NL*RW-1:0] err_rule;
    logic [LYW-1:0] err_layer, fwd_layer;
    logic [CW-1:0] err_x, err_y, fwd_y;
    logic [LW-1:0] fwd_xext;

    int total = 0, bad = 0;
    bit done = 0;
    int wt[3] = '{6, 24, 4};
    int st[9] = '{6, 12, 8, 12, 36, 5, 8, 5, 4};
    int xt[3] = '{12, 36, 8};
    int dl[16] = '{0, 1, 3, 4, 5, 6, 7, 8, 11, 12, 13, 23, 24, 35, 36, 37};

    always #5 clk = ~clk;

    rc_edge_rule_check i_rc_edge_rule_check (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Drive one word; returns on the next falling edge with its results out.
    task automatic send(input bit mk, input int y, input int l, input bit o,
                        input int k, input bit t, input bit ri);
        in_valid = 1; in_marker = mk; in_y = CW'(y); in_layer = LYW'(l);
        in_orient = o; in_kind = 2'(k); in_true = t; in_right_in = ri;
        @(negedge clk);
        in_valid = 0; in_marker = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!err_valid && !fwd_valid, "R1 in reset", {err_valid, fwd_valid}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!err_valid && !fwd_valid, "R1 after reset", {err_valid, fwd_valid}, 0);

        // Sweep layer pairs, orientations, kinds and distances.
        for (int a = 0; a < 3; a++)
        for (int b = 0; b < 3; b++)
        for (int po = 0; po < 2; po++)
        for (int co = 0; co < 2; co++)
        for (int pk = 0; pk < 3; pk += 2)
        for (int ck = 0; ck < 4; ck++)
        for (int di = 0; di < 16; di++) begin
            int xv, lim, rl, d, eh;
            bit rel, flag, viol, evirt, ev;
            d = dl[di];
            xv = (total % 500) + 1;
            send(1, xv, 0, 0, 0, 0, 0);
            send(0, 100, b, po[0], pk, 1, 0);
            if (pk == 0)
                chk(fwd_valid && !fwd_virtual && fwd_y == 100 && fwd_layer == b &&
                    fwd_orient == po[0], "R9 start forwarded as old",
                    {fwd_valid, fwd_virtual}, 2);
            send(0, 100 + d, a, co[0], ck, 1, 0);
            rel = 0; lim = 0; rl = 0;
            if (a == b && po == 0 && co == 1) begin
                rel = 1; lim = wt[a]; rl = a;                  // R2
            end else if (po == 1 && co == 0) begin
                rel = 1; lim = st[a*3+b]; rl = 3 + a*3 + b;    // R3
            end
            flag = (ck == 0) || (pk == 0);                     // R5
            viol = rel && flag && d > 0 && d < lim;            // R4
            eh = viol ? (1 << b) : 0;
            chk(err_valid == viol && err_hit == NL'(eh), "R2 R3 R4 R5 hit",
                {err_valid, err_hit}, {viol, 3'(eh)});
            if (viol)
                chk(err_rule[b*RW +: RW] == RW'(rl) && err_x == CW'(xv) &&
                    err_y == CW'(100 + d) && err_layer == a, "R11 error record",
                    err_rule[b*RW +: RW], rl);
            evirt = (ck == 1) && (co == 0);
            ev = (ck == 0) || evirt;
            chk(fwd_valid == ev && (!ev || fwd_virtual == evirt), "R9 R10 forward kind",
                {fwd_valid, fwd_virtual}, {ev, evirt});
        end

        // Virtual generation for every layer, orientation, side and truth.
        for (int l = 0; l < 3; l++)
        for (int o = 0; o < 2; o++)
        for (int ri = 0; ri < 2; ri++)
        for (int t = 0; t < 2; t++) begin
            bit ev;
            send(1, 9, 0, 0, 0, 0, 0);
            send(0, 200, l, o[0], 1, t[0], ri[0]);
            ev = t[0] && (o == 0 ? ri == 0 : ri == 1);
            chk(fwd_valid == ev && (!ev || (fwd_virtual && fwd_xext == LW'(xt[l]) &&
                fwd_y == 200 && fwd_layer == l && fwd_orient == o[0])),
                "R10 virtual point", {fwd_valid, fwd_xext}, {ev, 8'(ev ? xt[l] : 0)});
        end

        // Not-true start is still forwarded.
        send(0, 77, 2, 1, 0, 0, 0);
        chk(fwd_valid && !fwd_virtual && fwd_y == 77, "R9 non-true start", fwd_valid, 1);

        // Marker forgets latest points; X follows the marker.
        send(1, 5, 0, 0, 0, 0, 0);
        send(0, 100, 0, 0, 0, 1, 0);
        send(1, 7, 0, 0, 0, 0, 0);
        send(0, 102, 0, 1, 0, 1, 0);
        chk(!err_valid, "R8 marker clears", err_valid, 0);
        send(0, 104, 0, 0, 0, 1, 0);
        send(0, 106, 0, 1, 0, 1, 0);
        chk(err_valid && err_x == 7 && err_hit == 3'b001, "R8 column X", err_x, 7);

        // Virtual point leaves latest unchanged.
        send(1, 3, 0, 0, 0, 0, 0);
        send(0, 100, 0, 0, 0, 1, 0);
        send(0, 150, 0, 1, 3, 1, 0);
        chk(!err_valid, "R7 virtual far away", err_valid, 0);
        send(0, 103, 0, 1, 0, 1, 0);
        chk(err_valid && err_hit == 3'b001 && err_rule[3:0] == 0, "R7 virtual no update",
            err_hit, 1);

        // Not-true point leaves latest unchanged.
        send(1, 4, 0, 0, 0, 0, 0);
        send(0, 100, 0, 0, 0, 1, 0);
        send(0, 101, 0, 1, 2, 0, 0);
        chk(!err_valid, "R7 not-true no check", err_valid, 0);
        send(0, 104, 0, 1, 0, 1, 0);
        chk(err_valid && err_hit == 3'b001, "R7 not-true no update", err_hit, 1);

        // Two layers violate against one point.
        send(1, 8, 0, 0, 0, 0, 0);
        send(0, 100, 0, 1, 0, 1, 0);
        send(0, 101, 1, 1, 0, 1, 0);
        send(0, 104, 2, 0, 0, 1, 0);
        chk(err_hit == 3'b011 && err_rule[3:0] == 4'd9 && err_rule[7:4] == 4'd10,
            "R6 multi-layer", {err_hit, err_rule}, {3'b011, 12'h0a9});

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule